// File: doc/BRIEF.md
# DRAM Power-State and Command Legality Tracker

This block sits beside a graphics DRAM command bus and follows the device one clock at a time. It watches the clock-enable line and an already decoded command, and it works out where the device is: idle or with open banks, in precharge or active power-down, in self refresh, or inside one of the timed windows that follow an auto refresh, a mode register write, a power-down exit or a self-refresh exit. It keeps one open flag per bank.

Each edge is judged from the clock-enable level seen at the previous edge, the level at the current edge, the command and the state held just before the edge. A command that is not legal there is ignored and reported through a registered error flag and a 3-bit cause code, valid for one cycle after the offending edge. A debug view shows the state encoding and the clocks left in the running window. All delays are parameters counted in clocks.

Top module: `dram_pstate_tracker`

## Requirements
- R1: While rst_ni is low, the state reads 0, every bank flag is clear, err_o is low, the code is 0 and the window count is 0; the clock-enable level of the previous edge is taken as high after reset.
- R2: Command codes on cmd_i are 0 deselect, 1 no-op, 2 activate, 3 read, 4 read with auto-precharge, 5 write, 6 write with auto-precharge, 7 precharge, 8 auto refresh, 9 mode register write, 10 extended mode register write; codes 11 to 15 raise code 7 and change nothing.
- R3: With clock-enable high at both edges, an activate to a closed bank sets its flag; an activate to an open bank raises code 4 and is ignored.
- R4: An activate at fewer than T_RRD edges after the last accepted activate raises code 3 and is ignored; at exactly T_RRD edges later it is accepted.
- R5: Read or write to a closed bank raises code 5; the auto-precharge forms clear the addressed flag; precharge is always accepted and clears the addressed flag, or all flags when all_banks_i is high.
- R6: Auto refresh and both mode register writes need every bank closed, otherwise code 6; accepted, they open a window of T_RFC or T_MRD clocks, the next command being allowed T_RFC or T_MRD edges after the opening edge.
- R7: Inside a window, any command other than deselect or no-op, or clock-enable low, raises code 2 and is ignored; the count still falls by one per edge and the block returns to normal on the edge where the count is 1.
- R8: Clock-enable falling with deselect or no-op enters precharge power-down (state 2) when all banks are closed and active power-down (state 3) otherwise; falling with auto refresh and all banks closed enters self refresh (state 4).
- R9: In a power-down or self-refresh state, clock-enable low at the current edge keeps the state and raises no error, whatever the command; bank flags do not change outside the normal state.
- R10: Clock-enable rising in a power-down state opens a T_XPN window (state 7); rising in self refresh opens a T_XSR window (state 8); a command other than deselect or no-op on that edge raises code 1 and is ignored, but the exit still starts.
- R11: In the normal state, clock-enable low at the previous edge, or falling with any command not listed in R8, raises code 7 and leaves state and flags unchanged.
- R12: state_o reads 0 idle, 1 at least one bank open, 2 to 4 as in R8, 5 refresh window, 6 mode register window, 7 power-down exit window, 8 self-refresh exit window; win_cnt_o shows the edges left before the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Device clock-enable sample |
| cmd_i | input | 4 | Decoded command code |
| bank_i | input | BANK_W | Addressed bank |
| all_banks_i | input | 1 | Precharge applies to all banks |
| bank_active_o | output | NUM_BANKS | Open flag per bank |
| err_o | output | 1 | Illegal command seen at last edge |
| err_code_o | output | 3 | Cause of the error, 0 when none |
| state_o | output | 4 | State encoding for debug |
| win_cnt_o | output | WIN_W | Clocks left in the running window |

## Verification
A wrong state register shows at state_o on the very next sample and, one edge later, as a spurious or missing error code for the command that follows, since every command's legality depends on it. A window counter that is off by one lets a command through a clock early or rejects one a clock late, so the bench probes both edges of every window and the tRRD spacing. A lost or stuck bank flag shows on bank_active_o at once and later as a wrong code for a read, a refresh or a power-down entry.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam logic [3:0] CMD_DESEL = 4'd0;
  localparam logic [3:0] CMD_NOP   = 4'd1;
  localparam logic [3:0] CMD_ACT   = 4'd2;
  localparam logic [3:0] CMD_RD    = 4'd3;
  localparam logic [3:0] CMD_RDA   = 4'd4;
  localparam logic [3:0] CMD_WR    = 4'd5;
  localparam logic [3:0] CMD_WRA   = 4'd6;
  localparam logic [3:0] CMD_PRE   = 4'd7;
  localparam logic [3:0] CMD_AREF  = 4'd8;
  localparam logic [3:0] CMD_MRS   = 4'd9;
  localparam logic [3:0] CMD_EMRS  = 4'd10;

  localparam logic [2:0] ERR_NONE      = 3'd0;
  localparam logic [2:0] ERR_EXIT_CMD  = 3'd1;
  localparam logic [2:0] ERR_WIN_BUSY  = 3'd2;
  localparam logic [2:0] ERR_RRD       = 3'd3;
  localparam logic [2:0] ERR_ACT_OPEN  = 3'd4;
  localparam logic [2:0] ERR_BANK_IDLE = 3'd5;
  localparam logic [2:0] ERR_NOT_IDLE  = 3'd6;
  localparam logic [2:0] ERR_RSVD      = 3'd7;

  typedef enum logic [3:0] {
    ST_NORM   = 4'd0,
    ST_PPD    = 4'd2,
    ST_APD    = 4'd3,
    ST_SREF   = 4'd4,
    ST_W_AREF = 4'd5,
    ST_W_MRS  = 4'd6,
    ST_W_PDX  = 4'd7,
    ST_W_SRX  = 4'd8
  } st_e;

  function automatic logic is_quiet(logic [3:0] c);
    return (c == CMD_DESEL) || (c == CMD_NOP);
  endfunction
endpackage

// File: rtl/dpt_timer.sv
module dpt_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dpt_bank_flags.sv
module dpt_bank_flags #(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic                 clr_all_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] flags_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BANK_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         flags_o[g] <= 1'b0;
      else if (clr_all_i || (clr_i && hit)) flags_o[g] <= 1'b0;
      else if (set_i && hit)               flags_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dpt_ctrl.sv
module dpt_ctrl
  import dpt_pkg::*;
#(
  parameter int unsigned T_RFC = 12,
  parameter int unsigned T_MRD = 4,
  parameter int unsigned T_XPN = 3,
  parameter int unsigned T_XSR = 1000,
  parameter int unsigned WIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic [3:0]       cmd_i,
  input  logic             all_banks_i,
  input  logic             bank_open_i,
  input  logic             any_open_i,
  input  logic             rrd_free_i,
  input  logic [WIN_W-1:0] win_cnt_i,
  output st_e              st_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic             win_load_o,
  output logic [WIN_W-1:0] win_val_o,
  output logic             act_o,
  output logic             clr_o,
  output logic             clr_all_o
);
  localparam logic [WIN_W-1:0] LD_RFC = WIN_W'(T_RFC - 1);
  localparam logic [WIN_W-1:0] LD_MRD = WIN_W'(T_MRD - 1);
  localparam logic [WIN_W-1:0] LD_XPN = WIN_W'(T_XPN - 1);
  localparam logic [WIN_W-1:0] LD_XSR = WIN_W'(T_XSR - 1);

  st_e        st_q, st_d;
  logic       cke_q;
  logic [2:0] code_d;
  logic       quiet;

  assign quiet = is_quiet(cmd_i);

  always_comb begin
    st_d       = st_q;
    code_d     = ERR_NONE;
    win_load_o = 1'b0;
    win_val_o  = '0;
    act_o      = 1'b0;
    clr_o      = 1'b0;
    clr_all_o  = 1'b0;
    unique case (st_q)
      ST_NORM: begin
        if (!cke_q) begin
          code_d = ERR_RSVD;                 // exit from a state never entered
        end else if (!cke_i) begin
          if (quiet)                               st_d = any_open_i ? ST_APD : ST_PPD;
          else if (cmd_i == CMD_AREF && !any_open_i) st_d = ST_SREF;
          else                                     code_d = ERR_RSVD;
        end else begin
          case (cmd_i)
            CMD_DESEL, CMD_NOP: begin end
            CMD_ACT: begin
              if (bank_open_i)      code_d = ERR_ACT_OPEN;
              else if (!rrd_free_i) code_d = ERR_RRD;
              else                  act_o  = 1'b1;
            end
            CMD_RD, CMD_WR: begin
              if (!bank_open_i) code_d = ERR_BANK_IDLE;
            end
            CMD_RDA, CMD_WRA: begin
              if (!bank_open_i) code_d = ERR_BANK_IDLE;
              else              clr_o  = 1'b1;
            end
            CMD_PRE: begin
              clr_o     = !all_banks_i;
              clr_all_o = all_banks_i;
            end
            CMD_AREF: begin
              if (any_open_i) code_d = ERR_NOT_IDLE;
              else begin
                win_load_o = 1'b1;
                win_val_o  = LD_RFC;
                st_d       = (LD_RFC == '0) ? ST_NORM : ST_W_AREF;
              end
            end
            CMD_MRS, CMD_EMRS: begin
              if (any_open_i) code_d = ERR_NOT_IDLE;
              else begin
                win_load_o = 1'b1;
                win_val_o  = LD_MRD;
                st_d       = (LD_MRD == '0) ? ST_NORM : ST_W_MRS;
              end
            end
            default: code_d = ERR_RSVD;
          endcase
        end
      end
      ST_PPD, ST_APD, ST_SREF: begin
        if (cke_i) begin
          if (!quiet) code_d = ERR_EXIT_CMD;
          win_load_o = 1'b1;
          if (st_q == ST_SREF) begin
            win_val_o = LD_XSR;
            st_d      = (LD_XSR == '0) ? ST_NORM : ST_W_SRX;
          end else begin
            win_val_o = LD_XPN;
            st_d      = (LD_XPN == '0) ? ST_NORM : ST_W_PDX;
          end
        end
      end
      default: begin                         // timed windows
        if (!quiet || !cke_i) code_d = ERR_WIN_BUSY;
        if (win_cnt_i <= WIN_W'(1)) st_d = ST_NORM;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_NORM;
      cke_q      <= 1'b1;
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
    end else begin
      st_q       <= st_d;
      cke_q      <= cke_i;
      err_o      <= (code_d != ERR_NONE);
      err_code_o <= code_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/dram_pstate_tracker.sv
module dram_pstate_tracker
  import dpt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned T_RFC     = 12,
  parameter int unsigned T_MRD     = 4,
  parameter int unsigned T_XPN     = 3,
  parameter int unsigned T_XSR     = 1000,
  parameter int unsigned T_RRD     = 3,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned MAX_A    = (T_RFC > T_MRD) ? T_RFC : T_MRD,
  localparam int unsigned MAX_B    = (T_XPN > T_XSR) ? T_XPN : T_XSR,
  localparam int unsigned MAX_W    = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int unsigned WIN_W    = $clog2(MAX_W + 1),
  localparam int unsigned RRD_W    = $clog2(T_RRD + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic [3:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 all_banks_i,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic                 err_o,
  output logic [2:0]           err_code_o,
  output logic [3:0]           state_o,
  output logic [WIN_W-1:0]     win_cnt_o
);
  st_e              st;
  logic             win_load, act, clr, clr_all;
  logic [WIN_W-1:0] win_val, win_cnt;
  logic [RRD_W-1:0] rrd_cnt;
  logic [NUM_BANKS-1:0] flags;

  dpt_ctrl #(
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_XPN(T_XPN), .T_XSR(T_XSR), .WIN_W(WIN_W)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_i       (cke_i),
    .cmd_i       (cmd_i),
    .all_banks_i (all_banks_i),
    .bank_open_i (flags[bank_i]),
    .any_open_i  (|flags),
    .rrd_free_i  (rrd_cnt == '0),
    .win_cnt_i   (win_cnt),
    .st_o        (st),
    .err_o       (err_o),
    .err_code_o  (err_code_o),
    .win_load_o  (win_load),
    .win_val_o   (win_val),
    .act_o       (act),
    .clr_o       (clr),
    .clr_all_o   (clr_all)
  );

  dpt_timer #(.W(WIN_W)) i_win_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (win_load),
    .load_val_i (win_val),
    .cnt_o      (win_cnt)
  );

  dpt_timer #(.W(RRD_W)) i_rrd_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (act),
    .load_val_i (RRD_W'(T_RRD - 1)),
    .cnt_o      (rrd_cnt)
  );

  dpt_bank_flags #(.NUM_BANKS(NUM_BANKS)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (act),
    .clr_i     (clr),
    .clr_all_i (clr_all),
    .bank_i    (bank_i),
    .flags_o   (flags)
  );

  assign bank_active_o = flags;
  assign win_cnt_o     = win_cnt;
  assign state_o       = (st == ST_NORM && |flags) ? 4'd1 : 4'(st);
endmodule

// File: rtl/dpt_chk.sv
module dpt_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned WIN_W     = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_i,
  input logic [3:0]           cmd_i,
  input logic [NUM_BANKS-1:0] bank_active_o,
  input logic [3:0]           state_o,
  input logic [WIN_W-1:0]     win_cnt_o
);
  // R9
  pwr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 4'd2 || state_o == 4'd3 || state_o == 4'd4) && !cke_i) |=> $stable(state_o));

  // R9
  flag_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 4'd2) |=> $stable(bank_active_o));

  // R7
  win_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 4'd5 && win_cnt_o > WIN_W'(1)) |=> (win_cnt_o == $past(win_cnt_o) - WIN_W'(1)));

  // R7
  win_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 4'd5 && win_cnt_o > WIN_W'(1)) |=> $stable(state_o));

  // R3
  act_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != 4'd2 || !cke_i) |=> ((bank_active_o & ~$past(bank_active_o)) == '0));
endmodule

bind dram_pstate_tracker dpt_chk #(.NUM_BANKS(NUM_BANKS), .WIN_W(WIN_W)) i_dpt_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cke_i         (cke_i),
  .cmd_i         (cmd_i),
  .bank_active_o (bank_active_o),
  .state_o       (state_o),
  .win_cnt_o     (win_cnt_o)
);

// File: tb/test_dram_pstate_tracker.sv
module test_dram_pstate_tracker;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cke = 1'b1;
  logic [3:0] cmd = 4'd1;
  logic [1:0] bank = '0;
  logic       all_b = 1'b0;
  logic [NB-1:0] act_o;
  logic       err_o;
  logic [2:0] code_o;
  logic [3:0] st_o;
  logic [4:0] wcnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_pstate_tracker #(
    .NUM_BANKS(NB), .T_RFC(4), .T_MRD(2), .T_XPN(2), .T_XSR(20), .T_RRD(3)
  ) i_dram_pstate_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cmd_i(cmd), .bank_i(bank),
    .all_banks_i(all_b), .bank_active_o(act_o), .err_o(err_o),
    .err_code_o(code_o), .state_o(st_o), .win_cnt_o(wcnt_o)
  );

  typedef struct packed {
    logic       cke;
    logic [3:0] cmd;
    logic [1:0] bank;
    logic       all;
    logic [3:0] st;
    logic [2:0] code;
    logic [3:0] flags;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd0, 3'd0, 4'b0000, 4'd2 },  // R2 nop
    '{1'b1, 4'd2,  2'd0, 1'b0, 4'd1, 3'd0, 4'b0001, 4'd3 },  // R3 act b0
    '{1'b1, 4'd2,  2'd1, 1'b0, 4'd1, 3'd3, 4'b0001, 4'd4 },  // R4 too soon
    '{1'b1, 4'd0,  2'd0, 1'b0, 4'd1, 3'd0, 4'b0001, 4'd4 },  // R4
    '{1'b1, 4'd2,  2'd1, 1'b0, 4'd1, 3'd0, 4'b0011, 4'd4 },  // R4 exactly T_RRD
    '{1'b1, 4'd3,  2'd2, 1'b0, 4'd1, 3'd5, 4'b0011, 4'd5 },  // R5 rd idle bank
    '{1'b1, 4'd4,  2'd0, 1'b0, 4'd1, 3'd0, 4'b0010, 4'd5 },  // R5 rda closes
    '{1'b1, 4'd2,  2'd1, 1'b0, 4'd1, 3'd4, 4'b0010, 4'd3 },  // R3 act open bank
    '{1'b1, 4'd8,  2'd0, 1'b0, 4'd1, 3'd6, 4'b0010, 4'd6 },  // R6 aref not idle
    '{1'b0, 4'd1,  2'd0, 1'b0, 4'd3, 3'd0, 4'b0010, 4'd8 },  // R8 active pd
    '{1'b0, 4'd3,  2'd1, 1'b0, 4'd3, 3'd0, 4'b0010, 4'd9 },  // R9 stay
    '{1'b1, 4'd2,  2'd2, 1'b0, 4'd7, 3'd1, 4'b0010, 4'd10},  // R10 bad exit cmd
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd1, 3'd0, 4'b0010, 4'd10},  // R10 window done
    '{1'b1, 4'd7,  2'd0, 1'b1, 4'd0, 3'd0, 4'b0000, 4'd5 },  // R5 pre all
    '{1'b1, 4'd9,  2'd0, 1'b0, 4'd6, 3'd0, 4'b0000, 4'd6 },  // R6 mrs
    '{1'b1, 4'd2,  2'd0, 1'b0, 4'd0, 3'd2, 4'b0000, 4'd7 },  // R7 busy, last edge
    '{1'b1, 4'd8,  2'd0, 1'b0, 4'd5, 3'd0, 4'b0000, 4'd6 },  // R6 aref
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd5, 3'd0, 4'b0000, 4'd7 },  // R7
    '{1'b0, 4'd1,  2'd0, 1'b0, 4'd5, 3'd2, 4'b0000, 4'd7 },  // R7 cke low
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd0, 3'd0, 4'b0000, 4'd7 },  // R7 closes
    '{1'b1, 4'd2,  2'd3, 1'b0, 4'd1, 3'd0, 4'b1000, 4'd3 },  // R3
    '{1'b1, 4'd6,  2'd3, 1'b0, 4'd0, 3'd0, 4'b0000, 4'd5 },  // R5 wra closes
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd0, 3'd0, 4'b0000, 4'd4 },  // R4
    '{1'b1, 4'd2,  2'd2, 1'b0, 4'd1, 3'd0, 4'b0100, 4'd4 },  // R4
    '{1'b1, 4'd7,  2'd2, 1'b0, 4'd0, 3'd0, 4'b0000, 4'd5 },  // R5 pre one
    '{1'b1, 4'd15, 2'd0, 1'b0, 4'd0, 3'd7, 4'b0000, 4'd2 },  // R2 reserved
    '{1'b0, 4'd3,  2'd0, 1'b0, 4'd0, 3'd7, 4'b0000, 4'd11},  // R11 cke fall + rd
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd0, 3'd7, 4'b0000, 4'd11},  // R11 prev low
    '{1'b0, 4'd1,  2'd0, 1'b0, 4'd2, 3'd0, 4'b0000, 4'd8 },  // R8 precharge pd
    '{1'b0, 4'd1,  2'd0, 1'b0, 4'd2, 3'd0, 4'b0000, 4'd9 },  // R9
    '{1'b1, 4'd0,  2'd0, 1'b0, 4'd7, 3'd0, 4'b0000, 4'd10},  // R10
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd0, 3'd0, 4'b0000, 4'd10},  // R10
    '{1'b0, 4'd8,  2'd0, 1'b0, 4'd4, 3'd0, 4'b0000, 4'd8 },  // R8 self refresh
    '{1'b0, 4'd2,  2'd0, 1'b0, 4'd4, 3'd0, 4'b0000, 4'd9 },  // R9
    '{1'b1, 4'd1,  2'd0, 1'b0, 4'd8, 3'd0, 4'b0000, 4'd10},  // R10 sr exit
    '{1'b1, 4'd10, 2'd0, 1'b0, 4'd8, 3'd2, 4'b0000, 4'd7 }   // R7 emrs in window
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] c, input logic [1:0] b, input logic a);
    cke = k; cmd = c; bank = b; all_b = a;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_out(input string req, input int st, input int code, input int fl);
    chk(req, "state", int'(st_o), st);
    chk(req, "code", int'(code_o), code);
    chk(req, "err", int'(err_o), int'(code != 0));
    chk(req, "flags", int'(act_o), fl);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_out("R1", 0, 0, 0);
    chk("R1", "win", int'(wcnt_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].cke, VEC[i].cmd, VEC[i].bank, VEC[i].all);
      chk_out($sformatf("R%0d vec%0d", VEC[i].req, i), int'(VEC[i].st),
              int'(VEC[i].code), int'(VEC[i].flags));
      @(negedge clk);
    end

    // R12 self-refresh exit window count after busy edge
    chk("R12", "win", int'(wcnt_o), 18);
    for (int i = 0; i < 17; i++) begin
      step(1'b1, 4'd1, 2'd0, 1'b0);
      @(negedge clk);
    end
    chk("R10", "state", int'(st_o), 8);
    chk("R12", "win", int'(wcnt_o), 1);
    step(1'b1, 4'd1, 2'd0, 1'b0);
    chk("R10", "state", int'(st_o), 0);
    chk("R12", "win", int'(wcnt_o), 0);
    @(negedge clk);

    // R6 emrs with an open bank
    step(1'b1, 4'd2, 2'd0, 1'b0);
    @(negedge clk);
    step(1'b1, 4'd10, 2'd0, 1'b0);
    chk_out("R6", 1, 6, 4'b0001);
    @(negedge clk);

    // R12 refresh window count right after opening
    step(1'b1, 4'd7, 2'd0, 1'b1);
    @(negedge clk);
    step(1'b1, 4'd8, 2'd0, 1'b0);
    chk("R12", "win", int'(wcnt_o), 3);
    chk("R12", "state", int'(st_o), 5);
    @(negedge clk);

    // R1 asynchronous reset mid-window
    rst_ni = 1'b0;
    #1;
    chk_out("R1", 0, 0, 0);
    chk("R1", "win", int'(wcnt_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 previous clock-enable taken as high: plain no-op is legal
    step(1'b1, 4'd1, 2'd0, 1'b0);
    chk_out("R1", 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule